// File: doc/BRIEF.md
# Receive Destination Address Filter with Loadable Match Table

This block decides whether an arriving frame is kept, based only on its 48-bit destination address. It also says whether the frame was kept as multicast or as broadcast. Inside sits a table of sixteen 48-bit addresses and a 16-bit mask that chooses which table entries take part in matching. All sixteen comparisons run in parallel. The result is registered and appears one clock after the lookup strobe.

The table is filled by a load sequencer. It walks a list of descriptors in memory through a request/acknowledge read port. Each descriptor carries an entry index and three address words. After the last descriptor, one more word is read and becomes the new enable mask. While the controller is held in its reset mode, three read ports show the words of one chosen table entry. Outside reset mode those ports read zero. A lookup that arrives during a load is held and evaluated as soon as the load finishes, so it sees the updated table.

Top module: `rxaddr_cam_filter`

## Requirements
- R1: With `mode_promisc` set, a destination whose byte 0 (`dst_addr[7:0]`, first on the wire) has bit 0 clear is accepted with `res_flags` zero, even if it is not in the table. Promiscuous mode alone never accepts a destination whose `dst_addr[0]` is 1.
- R2: With `mode_all_mcast` set, a destination with `dst_addr[0]` = 1 is accepted with `res_flags` = 16'h0100 (bit 8, multicast). This holds when R1 does not apply.
- R3: With `mode_bcast` set, the all-ones destination is accepted with `res_flags` = 16'h0080 (bit 7, broadcast). This holds when neither R1 nor R2 applies. Bits 8 and 7 are never set together, and they are set only on an accept.
- R4: If R1 to R3 do not apply, a destination equal to a table entry whose enable-mask bit is set is accepted with `res_flags` zero. Any other destination is rejected (`res_accept` = 0, `res_flags` = 0). An entry stores `dst_addr[15:0]` as word 0, `[31:16]` as word 1 and `[47:32]` as word 2.
- R5: `res_valid` is high for exactly the one cycle after a `dst_valid` cycle taken while no load is running. It is low otherwise.
- R6: For each descriptor a load reads four words: the entry index (low 4 bits used), then address words 0, 1 and 2. The reads go to `{desc_upper, ptr+0, +2, +4, +6}` when `wide_mode` = 0, or to `{desc_upper, ptr+0, +4, +8, +12}` when it is 1. `mem_req` and `mem_addr` are held until `mem_ack`.
- R7: After each descriptor, the count drops by one and the pointer moves up by 8 bytes (16-bit mode) or 16 bytes (wide mode). When the count reaches zero, one word is read at the current pointer and replaces the enable mask. Then `load_busy` falls and `load_done` rises. A count of zero reads only the mask word.
- R8: While `ctl_in_reset` is 1, `port_w2`, `port_w1` and `port_w0` return words 2, 1 and 0 of entry `cam_ptr`. While it is 0, they read zero.
- R9: A lookup strobed while `load_busy` is 1 produces no result during the load. It is evaluated against the new table on the first clock after `load_busy` falls.
- R10: `load_done` stays set until the next accepted `load_start`, which clears it. A `load_start` while `load_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_in_reset | input | 1 | Controller is in reset mode (enables table read ports) |
| mode_promisc | input | 1 | Accept any unicast destination |
| mode_all_mcast | input | 1 | Accept any multicast destination |
| mode_bcast | input | 1 | Accept the broadcast destination |
| wide_mode | input | 1 | Descriptor words on 32-bit stride |
| load_start | input | 1 | Start a table load |
| load_count | input | 5 | Number of descriptors to load |
| desc_upper | input | 16 | Upper 16 bits of descriptor addresses |
| desc_ptr | input | 16 | Starting descriptor pointer (low 16 bits) |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Sticky load-complete status |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| dst_valid | input | 1 | Lookup strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Lookup result valid |
| res_accept | output | 1 | Frame accepted |
| res_flags | output | 16 | Type flags: bit 8 multicast, bit 7 broadcast |
| cam_ptr | input | 4 | Entry selected for read-back |
| port_w2 | output | 16 | Word 2 of selected entry (reset mode only) |
| port_w1 | output | 16 | Word 1 of selected entry (reset mode only) |
| port_w0 | output | 16 | Word 0 of selected entry (reset mode only) |

## Verification
The bench targets the priority ladder. If promiscuous mode were applied to all frames, a multicast destination would pass with no flag. If broadcast were checked before multicast, the all-ones address would come back with bit 7 instead of bit 8. An entry stored in the table but left out of the mask must reject, and a design that ignored the mask would accept it. The load walk is checked by read counts and the last address in both strides, and a zero-count load must read just the mask. A lookup issued during a load must return only after the load ends and must match the freshly loaded entry; a design that answered at once would reject it or answer while still busy.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FLAG_W      = 16;
  localparam int FLAG_MC_BIT = 8;
  localparam int FLAG_BC_BIT = 7;

  typedef enum logic [0:0] {
    LD_IDLE  = 1'b0,
    LD_FETCH = 1'b1
  } ld_state_e;
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxf_loader.sv
module rxf_loader
  import rxf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48,
  parameter int WORD_W  = 16,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_start,
  input  logic [CNT_W-1:0]           load_count,
  input  logic [WORD_W-1:0]          desc_upper,
  input  logic [WORD_W-1:0]          desc_ptr,
  input  logic                       wide_mode,
  output logic                       mem_req,
  output logic [2*WORD_W-1:0]        mem_addr,
  input  logic                       mem_ack,
  input  logic [WORD_W-1:0]          mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic                       ent_we,
  output logic [$clog2(ENTRIES)-1:0] ent_idx,
  output logic [ADDR_W-1:0]          ent_data,
  output logic                       mask_we,
  output logic [ENTRIES-1:0]         mask_data
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int WORDS = ADDR_W / WORD_W;
  localparam int PH_W  = $clog2(WORDS + 1);

  ld_state_e             state_q, state_d;
  logic [PH_W-1:0]       phase_q, phase_d;
  logic                  mphase_q, mphase_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [WORD_W-1:0]     ptr_q, ptr_d;
  logic [WORD_W-1:0]     upper_q;
  logic                  wide_q;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [ADDR_W-1:0]     acc_q, acc_d;
  logic                  done_q, done_d;
  logic [WORD_W-1:0]     offset;
  logic                  start_ok;

  assign start_ok = load_start && (state_q == LD_IDLE);
  assign offset   = WORD_W'(phase_q) << (wide_q ? 2 : 1);

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    mphase_d  = mphase_q;
    cnt_d     = cnt_q;
    ptr_d     = ptr_q;
    idx_d     = idx_q;
    acc_d     = acc_q;
    done_d    = done_q;
    ent_we    = 1'b0;
    mask_we   = 1'b0;
    if (start_ok) begin
      state_d  = LD_FETCH;
      phase_d  = '0;
      mphase_d = (load_count == '0);
      cnt_d    = load_count;
      ptr_d    = desc_ptr;
      done_d   = 1'b0;
    end else if (state_q == LD_FETCH && mem_ack) begin
      if (mphase_q) begin
        mask_we = 1'b1;
        done_d  = 1'b1;
        state_d = LD_IDLE;
      end else if (phase_q == '0) begin
        idx_d   = mem_rdata[IDX_W-1:0];
        phase_d = phase_q + 1'b1;
      end else begin
        acc_d[(int'(phase_q) - 1) * WORD_W +: WORD_W] = mem_rdata;
        if (int'(phase_q) == WORDS) begin
          ent_we   = 1'b1;
          phase_d  = '0;
          cnt_d    = cnt_q - 1'b1;
          ptr_d    = ptr_q + (wide_q ? WORD_W'(16) : WORD_W'(8));
          mphase_d = (cnt_q == CNT_W'(1));
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LD_IDLE;
      phase_q  <= '0;
      mphase_q <= 1'b0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      upper_q  <= '0;
      wide_q   <= 1'b0;
      idx_q    <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      mphase_q <= mphase_d;
      cnt_q    <= cnt_d;
      ptr_q    <= ptr_d;
      idx_q    <= idx_d;
      acc_q    <= acc_d;
      done_q   <= done_d;
      if (start_ok) begin
        upper_q <= desc_upper;
        wide_q  <= wide_mode;
      end
    end
  end

  assign mem_req   = (state_q == LD_FETCH);
  assign mem_addr  = {upper_q, ptr_q + offset};
  assign busy      = (state_q != LD_IDLE);
  assign done      = done_q;
  assign ent_idx   = idx_q;
  assign ent_data  = acc_d;
  assign mask_data = mem_rdata[ENTRIES-1:0];
endmodule

// File: rtl/rxf_cam_store.sv
module rxf_cam_store #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48,
  parameter int WORD_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ent_we,
  input  logic [$clog2(ENTRIES)-1:0]        ent_idx,
  input  logic [ADDR_W-1:0]                 ent_data,
  input  logic                              mask_we,
  input  logic [ENTRIES-1:0]                mask_data,
  input  logic                              rd_allow,
  input  logic [$clog2(ENTRIES)-1:0]        rd_idx,
  output logic [ENTRIES-1:0][ADDR_W-1:0]    table_flat,
  output logic [ENTRIES-1:0]                en_mask,
  output logic [WORD_W-1:0]                 rd_w2,
  output logic [WORD_W-1:0]                 rd_w1,
  output logic [WORD_W-1:0]                 rd_w0
);
  logic [ADDR_W-1:0] sel_entry;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic row_we;
    assign row_we = ent_we && (int'(ent_idx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      table_flat[g] <= '0;
      else if (row_we) table_flat[g] <= ent_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_mask <= '0;
    else if (mask_we) en_mask <= mask_data;
  end

  assign sel_entry = table_flat[rd_idx];
  assign rd_w0 = rd_allow ? sel_entry[0*WORD_W +: WORD_W] : '0;
  assign rd_w1 = rd_allow ? sel_entry[1*WORD_W +: WORD_W] : '0;
  assign rd_w2 = rd_allow ? sel_entry[2*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           busy,
  input  logic                           dst_valid,
  input  logic [ADDR_W-1:0]              dst_addr,
  input  logic                           mode_promisc,
  input  logic                           mode_all_mcast,
  input  logic                           mode_bcast,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] table_flat,
  input  logic [ENTRIES-1:0]             en_mask,
  output logic                           res_valid,
  output logic                           res_accept,
  output logic [FLAG_W-1:0]              res_flags
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              eval_now;
  logic [ADDR_W-1:0] eval_addr;
  logic [ENTRIES-1:0] hit;
  logic              is_group, is_bcast;
  logic              acc_d;
  logic [FLAG_W-1:0] flg_d;

  assign eval_now  = !busy && (pend_q || dst_valid);
  assign eval_addr = pend_q ? paddr_q : dst_addr;
  assign is_group  = eval_addr[0];
  assign is_bcast  = &eval_addr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = en_mask[g] && (table_flat[g] == eval_addr);
  end

  always_comb begin
    acc_d = 1'b0;
    flg_d = '0;
    if (mode_promisc && !is_group) begin
      acc_d = 1'b1;
    end else if (mode_all_mcast && is_group) begin
      acc_d = 1'b1;
      flg_d[FLAG_MC_BIT] = 1'b1;
    end else if (mode_bcast && is_bcast) begin
      acc_d = 1'b1;
      flg_d[FLAG_BC_BIT] = 1'b1;
    end else if (|hit) begin
      acc_d = 1'b1;
    end
  end

  always_comb begin
    pend_d  = pend_q;
    paddr_d = paddr_q;
    if (busy) begin
      if (dst_valid) begin
        pend_d  = 1'b1;
        paddr_d = dst_addr;
      end
    end else if (pend_q) begin
      pend_d = dst_valid;
      if (dst_valid) paddr_d = dst_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      paddr_q    <= '0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_flags  <= '0;
    end else begin
      pend_q    <= pend_d;
      paddr_q   <= paddr_d;
      res_valid <= eval_now;
      if (eval_now) begin
        res_accept <= acc_d;
        res_flags  <= flg_d;
      end
    end
  end
endmodule

// File: rtl/rxaddr_cam_filter.sv
module rxaddr_cam_filter
  import rxf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48,
  parameter int WORD_W  = 16,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_in_reset,
  input  logic                mode_promisc,
  input  logic                mode_all_mcast,
  input  logic                mode_bcast,
  input  logic                wide_mode,
  input  logic                load_start,
  input  logic [CNT_W-1:0]    load_count,
  input  logic [WORD_W-1:0]   desc_upper,
  input  logic [WORD_W-1:0]   desc_ptr,
  output logic                load_busy,
  output logic                load_done,
  output logic                mem_req,
  output logic [2*WORD_W-1:0] mem_addr,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                dst_valid,
  input  logic [ADDR_W-1:0]   dst_addr,
  output logic                res_valid,
  output logic                res_accept,
  output logic [FLAG_W-1:0]   res_flags,
  input  logic [IDX_W-1:0]    cam_ptr,
  output logic [WORD_W-1:0]   port_w2,
  output logic [WORD_W-1:0]   port_w1,
  output logic [WORD_W-1:0]   port_w0
);
  logic                           rst_n_int;
  logic                           ent_we, mask_we;
  logic [IDX_W-1:0]               ent_idx;
  logic [ADDR_W-1:0]              ent_data;
  logic [ENTRIES-1:0]             mask_data, en_mask;
  logic [ENTRIES-1:0][ADDR_W-1:0] table_flat;

  rxf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxf_loader #(
    .ENTRIES (ENTRIES), .ADDR_W (ADDR_W), .WORD_W (WORD_W), .CNT_W (CNT_W)
  ) u_loader (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_start (load_start),
    .load_count (load_count),
    .desc_upper (desc_upper),
    .desc_ptr   (desc_ptr),
    .wide_mode  (wide_mode),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .busy       (load_busy),
    .done       (load_done),
    .ent_we     (ent_we),
    .ent_idx    (ent_idx),
    .ent_data   (ent_data),
    .mask_we    (mask_we),
    .mask_data  (mask_data)
  );

  rxf_cam_store #(
    .ENTRIES (ENTRIES), .ADDR_W (ADDR_W), .WORD_W (WORD_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ent_we     (ent_we),
    .ent_idx    (ent_idx),
    .ent_data   (ent_data),
    .mask_we    (mask_we),
    .mask_data  (mask_data),
    .rd_allow   (ctl_in_reset),
    .rd_idx     (cam_ptr),
    .table_flat (table_flat),
    .en_mask    (en_mask),
    .rd_w2      (port_w2),
    .rd_w1      (port_w1),
    .rd_w0      (port_w0)
  );

  rxf_match #(
    .ENTRIES (ENTRIES), .ADDR_W (ADDR_W)
  ) u_match (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .busy           (load_busy),
    .dst_valid      (dst_valid),
    .dst_addr       (dst_addr),
    .mode_promisc   (mode_promisc),
    .mode_all_mcast (mode_all_mcast),
    .mode_bcast     (mode_bcast),
    .table_flat     (table_flat),
    .en_mask        (en_mask),
    .res_valid      (res_valid),
    .res_accept     (res_accept),
    .res_flags      (res_flags)
  );
endmodule

// File: rtl/rxaddr_cam_filter_chk.sv
module rxaddr_cam_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_in_reset,
  input logic        load_busy,
  input logic        load_done,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        res_valid,
  input logic        res_accept,
  input logic [15:0] res_flags,
  input logic [15:0] port_w2,
  input logic [15:0] port_w1,
  input logic [15:0] port_w0
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_flags[8] && res_flags[7])); // R3

  AST_FLAGS_NEED_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_flags != 16'h0000)) |-> res_accept); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> !load_busy); // R7

  AST_PORTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_in_reset |-> (port_w2 == 16'h0 && port_w1 == 16'h0 && port_w0 == 16'h0)); // R8

  AST_NO_RESULT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_busy) |-> !res_valid); // R9
endmodule

bind rxaddr_cam_filter rxaddr_cam_filter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_in_reset (ctl_in_reset),
  .load_busy    (load_busy),
  .load_done    (load_done),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .res_valid    (res_valid),
  .res_accept   (res_accept),
  .res_flags    (res_flags),
  .port_w2      (port_w2),
  .port_w1      (port_w1),
  .port_w0      (port_w0)
);

// File: tb/rxaddr_cam_filter_tb_top.sv
module rxaddr_cam_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_in_reset = 1'b0;
  logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_bcast = 1'b0;
  logic        wide_mode = 1'b0;
  logic        load_start = 1'b0;
  logic [4:0]  load_count = '0;
  logic [15:0] desc_upper = 16'h0042, desc_ptr = '0;
  logic        load_busy, load_done, mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        res_valid, res_accept;
  logic [15:0] res_flags;
  logic [3:0]  cam_ptr = '0;
  logic [15:0] port_w2, port_w1, port_w0;

  int checks = 0, failures = 0, reads = 0;
  logic [31:0] last_addr = '0;
  logic [15:0] bmem [0:1023];
  bit finished = 0;

  localparam logic [47:0] A_ADR = 48'h6655_4433_2210;
  localparam logic [47:0] B_ADR = 48'h0A0B_0C0D_0E0C;
  localparam logic [47:0] C_ADR = 48'h1234_5678_9A0E;
  localparam logic [47:0] D_ADR = 48'hC0FF_EE00_BE02;
  localparam logic [47:0] E_ADR = 48'h7777_7777_7700;
  localparam logic [47:0] U_ADR = 48'h0102_0304_0506;
  localparam logic [47:0] M_ADR = 48'h0000_005E_0001;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  rxaddr_cam_filter dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_in_reset(ctl_in_reset),
    .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast),
    .mode_bcast(mode_bcast), .wide_mode(wide_mode), .load_start(load_start),
    .load_count(load_count), .desc_upper(desc_upper), .desc_ptr(desc_ptr),
    .load_busy(load_busy), .load_done(load_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .res_valid(res_valid),
    .res_accept(res_accept), .res_flags(res_flags), .cam_ptr(cam_ptr),
    .port_w2(port_w2), .port_w1(port_w1), .port_w0(port_w0)
  );

  // memory responder: acknowledges one cycle after each request
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      mem_rdata = bmem[mem_addr[10:1]];
      last_addr = mem_addr;
      reads++;
      mem_ack = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_entry(input int base, input bit wide, input logic [15:0] idx, input logic [47:0] a);
    int st = wide ? 4 : 2;
    bmem[(base) >> 1]          = idx;
    bmem[(base + st) >> 1]     = a[15:0];
    bmem[(base + 2*st) >> 1]   = a[31:16];
    bmem[(base + 3*st) >> 1]   = a[47:32];
  endtask

  task automatic do_load(input logic [15:0] ptr, input logic [4:0] cnt, input bit wide);
    @(negedge clk);
    desc_ptr = ptr; load_count = cnt; wide_mode = wide; load_start = 1'b1; reads = 0;
    @(negedge clk);
    load_start = 1'b0;
    for (int i = 0; i < 400 && load_busy; i++) @(negedge clk);
  endtask

  task automatic lookup(input logic [47:0] a, input bit pr, input bit am, input bit bc,
                        input bit exp_acc, input logic [15:0] exp_fl, input string req);
    @(negedge clk);
    mode_promisc = pr; mode_all_mcast = am; mode_bcast = bc;
    dst_addr = a; dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
    check(res_valid == 1'b1, {req, " valid"}, res_valid, 1);
    check(res_accept == exp_acc, {req, " accept"}, res_accept, exp_acc);
    check(res_flags == exp_fl, {req, " flags"}, res_flags, exp_fl);
    @(negedge clk);
    check(res_valid == 1'b0, "R5 single pulse", res_valid, 0);
  endtask

  task automatic t_reset;
    check(res_valid == 0, "R5 reset valid", res_valid, 0);
    check(load_busy == 0 && load_done == 0, "R10 reset load state", {load_busy, load_done}, 0);
    check(mem_req == 0, "R6 reset req", mem_req, 0);
    check({port_w2, port_w1, port_w0} == '0, "R8 reset ports", {port_w2, port_w1, port_w0}, 0);
  endtask

  task automatic t_load_narrow;
    put_entry(16'h0100, 0, 16'hFFF5, A_ADR);
    put_entry(16'h0108, 0, 16'h0000, B_ADR);
    put_entry(16'h0110, 0, 16'h000F, C_ADR);
    bmem[16'h0118 >> 1] = 16'h0021;
    do_load(16'h0100, 5'd3, 0);
    check(reads == 13, "R6 narrow read count", reads, 13);
    check(last_addr == 32'h0042_0118, "R7 narrow mask address", last_addr, 32'h0042_0118);
    check(!load_busy && load_done, "R7 load finish", {load_busy, load_done}, 2'b01);
  endtask

  task automatic t_readback;
    @(negedge clk);
    ctl_in_reset = 1'b1; cam_ptr = 4'h5;
    @(negedge clk);
    check({port_w2, port_w1, port_w0} == A_ADR, "R8 entry 5 words", {port_w2, port_w1, port_w0}, A_ADR);
    cam_ptr = 4'h0;
    @(negedge clk);
    check({port_w2, port_w1, port_w0} == B_ADR, "R8 entry 0 words", {port_w2, port_w1, port_w0}, B_ADR);
    ctl_in_reset = 1'b0;
    @(negedge clk);
    check({port_w2, port_w1, port_w0} == '0, "R8 zero outside reset", {port_w2, port_w1, port_w0}, 0);
  endtask

  task automatic t_filter;
    lookup(A_ADR, 0, 0, 0, 1, 16'h0000, "R4 enabled entry A");
    lookup(B_ADR, 0, 0, 0, 1, 16'h0000, "R4 enabled entry B");
    lookup(C_ADR, 0, 0, 0, 0, 16'h0000, "R4 masked entry C");
    lookup(U_ADR, 0, 0, 0, 0, 16'h0000, "R4 unknown unicast");
    lookup(U_ADR, 1, 0, 0, 1, 16'h0000, "R1 promisc unicast");
    lookup(M_ADR, 1, 0, 0, 0, 16'h0000, "R1 promisc multicast");
    lookup(M_ADR, 0, 1, 0, 1, 16'h0100, "R2 all multicast");
    lookup(BCAST, 0, 0, 1, 1, 16'h0080, "R3 broadcast");
    lookup(BCAST, 0, 1, 1, 1, 16'h0100, "R3 multicast before broadcast");
    lookup(BCAST, 0, 0, 0, 0, 16'h0000, "R3 broadcast disabled");
    lookup(A_ADR, 1, 1, 1, 1, 16'h0000, "R1 promisc over table");
  endtask

  task automatic t_load_wide;
    put_entry(16'h0200, 1, 16'h0003, D_ADR);
    bmem[16'h0210 >> 1] = 16'h0008;
    do_load(16'h0200, 5'd1, 1);
    check(reads == 5, "R6 wide read count", reads, 5);
    check(last_addr == 32'h0042_0210, "R7 wide mask address", last_addr, 32'h0042_0210);
    lookup(D_ADR, 0, 0, 0, 1, 16'h0000, "R6 wide entry D");
    lookup(A_ADR, 0, 0, 0, 0, 16'h0000, "R7 mask replaced");
  endtask

  task automatic t_load_zero;
    bmem[16'h0300 >> 1] = 16'h0021;
    do_load(16'h0300, 5'd0, 0);
    check(reads == 1, "R7 zero count reads", reads, 1);
    check(last_addr == 32'h0042_0300, "R7 zero count address", last_addr, 32'h0042_0300);
    lookup(A_ADR, 0, 0, 0, 1, 16'h0000, "R7 mask only reload");
  endtask

  task automatic t_deferred;
    bit seen = 0;
    put_entry(16'h0400, 0, 16'h0007, E_ADR);
    bmem[16'h0408 >> 1] = 16'h0080;
    mode_promisc = 0; mode_all_mcast = 0; mode_bcast = 0;
    @(negedge clk);
    desc_ptr = 16'h0400; load_count = 5'd1; wide_mode = 0; load_start = 1'b1; reads = 0;
    @(negedge clk);
    check(load_busy && !load_done, "R10 done cleared by start", {load_busy, load_done}, 2'b10);
    desc_ptr = 16'h0100; load_count = 5'd3;
    dst_addr = E_ADR; dst_valid = 1'b1;
    @(negedge clk);
    load_start = 1'b0; dst_valid = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      if (res_valid) seen = 1;
      else @(negedge clk);
    end
    check(seen && !load_busy, "R9 result after load", {seen, load_busy}, 2'b10);
    check(res_accept == 1'b1, "R9 uses new table", res_accept, 1);
    check(reads == 5, "R10 start during busy ignored", reads, 5);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 16'hDEAD;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_load_narrow();
    t_readback();
    t_filter();
    t_load_wide();
    t_load_zero();
    t_deferred();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule